// File: doc/BRIEF.md
# Write-Back Data Cache with No-Fill Scratch Mode

This block is a small direct-mapped write-back data cache placed between a CPU load/store port and an external memory that moves whole lines. Two configuration inputs select its mode. `cfg_cd` stops the cache from taking new lines. `cfg_nw` stops writes to resident lines from ever reaching memory. With both set, the lines already resident behave as private scratch storage. Code can then run with its stack and data held entirely inside the cache, and nothing is written to memory.

Two maintenance commands are accepted as single-cycle pulses. The discard command drops every line at once, including modified data, and never touches memory. The flush command walks the lines, writes each modified line out, and invalidates it. While a command runs the block reports busy and holds off CPU requests. A one-cycle completion pulse marks the end of the command.

A CPU request is taken when `cpu_req_valid` and `cpu_req_ready` are both high. Exactly one `cpu_rsp_valid` pulse answers each request, and on a read it carries the addressed word.

Top module: `nfc_cache`

## Requirements
- R1: After reset, all lines are invalid, `busy` and `done` are low and `cpu_req_ready` is high. With `cfg_cd=0` and `cfg_nw=0` the cache allocates on a miss.
- R2: With `cfg_cd=0`, a read miss issues one line read and installs the line. Later reads of that line are answered from the cache with no memory request.
- R3: With both configuration bits low, a write hit updates only the cache and marks the line modified. A modified victim is written back as a full line (all 16 byte strobes set) before the replacement is read.
- R4: With both configuration bits low, a write miss reads the line, merges the bytes selected by `cpu_req_be` (bit n covers data bits 8n+7..8n), and leaves the line modified.
- R5: With `cfg_cd=1`, a read that hits is served from the cache and issues no memory read.
- R6: With `cfg_cd=1`, a miss never allocates. A read issues one line read and returns the word selected by address bits 3:2. A write issues one line write whose strobes cover only the addressed bytes, where line byte k corresponds to address bits 3:0 equal to k.
- R7: With `cfg_cd=1` and `cfg_nw=0`, a write hit updates the line and also writes those bytes through to memory.
- R8: With `cfg_nw=1`, a write hit updates the line and issues no memory write. Data written this way is never written out later, whether by eviction or after `cfg_nw` returns to 0.
- R9: The discard command (`cmd_inv`) invalidates every line and issues no memory write.
- R10: The flush command (`cmd_wbinv`) writes each modified line to memory exactly once and leaves every line invalid.
- R11: While a command runs, `busy` is high and `cpu_req_ready` is low. Completion is marked by `done` high for exactly one cycle, with `busy` low again.
- R12: Every memory request carries a 16-byte aligned address (bits 3:0 zero) and is held stable until `mem_req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cd | input | 1 | Stop allocating new lines |
| cfg_nw | input | 1 | Keep write hits inside the cache |
| cmd_inv | input | 1 | Pulse: discard all lines |
| cmd_wbinv | input | 1 | Pulse: write back modified lines, then invalidate |
| busy | output | 1 | A maintenance command is running |
| done | output | 1 | One-cycle pulse when a command completes |
| cpu_req_valid | input | 1 | CPU request present |
| cpu_req_ready | output | 1 | Request accepted this cycle if valid |
| cpu_req_we | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | 32 | Byte address |
| cpu_req_wdata | input | 32 | Store data |
| cpu_req_be | input | 4 | Store byte enables |
| cpu_rsp_valid | output | 1 | One-cycle response pulse |
| cpu_rsp_rdata | output | 32 | Load data |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = line write, 0 = line read |
| mem_req_addr | output | 32 | Line-aligned address |
| mem_req_wdata | output | 128 | Line write data |
| mem_req_be | output | 16 | Byte strobes for a write |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_rdata | input | 128 | Returned line |

## Verification
The bench uses the default parameters: 16 lines of 16 bytes, a 32-bit word and 32-bit addresses. All of its addresses lie below 4 KiB, so addresses 0x100, 0x900 and 0xA00 share an index with different tags. That makes eviction of modified lines and of lines written under `cfg_nw` easy to provoke. The memory model counts reads and writes, which turns every "no memory traffic" requirement into a counter comparison, and it checks the alignment of every request.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_LOOK,
        S_EVICT,
        S_RD_REQ,
        S_RD_WAIT,
        S_WR_MEM,
        S_INV,
        S_WB_SCAN,
        S_WB_WR
    } nfc_state_e;

endpackage

// File: rtl/nfc_store.sv
module nfc_store #(
    parameter int LINES  = 16,
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 24,
    parameter int LINE_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic              rd_dirty,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_valid,
    input  logic              wr_dirty,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [LINE_W-1:0] wr_line,
    input  logic              clr_all
);
    logic [LINES-1:0]  valid_d, valid_q;
    logic [LINES-1:0]  dirty_d, dirty_q;
    logic [TAG_W-1:0]  tag_d  [LINES];
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [LINE_W-1:0] line_d [LINES];
    logic [LINE_W-1:0] line_q [LINES];
    logic [LINES-1:0]  wsel;

    // one-hot write decode, one bit per line
    for (genvar g = 0; g < LINES; g++) begin : g_dec
        assign wsel[g] = wr_en && (wr_idx == IDX_W'(g));
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_line  = line_q[rd_idx];

    always_comb begin
        for (int i = 0; i < LINES; i++) begin
            valid_d[i] = clr_all ? 1'b0 : valid_q[i];
            dirty_d[i] = clr_all ? 1'b0 : dirty_q[i];
            tag_d[i]   = tag_q[i];
            line_d[i]  = line_q[i];
            if (wsel[i]) begin
                valid_d[i] = wr_valid;
                dirty_d[i] = wr_dirty;
                tag_d[i]   = wr_tag;
                line_d[i]  = wr_line;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
            for (int i = 0; i < LINES; i++) begin
                tag_q[i]  <= '0;
                line_q[i] <= '0;
            end
        end else begin
            valid_q <= valid_d;
            dirty_q <= dirty_d;
            for (int i = 0; i < LINES; i++) begin
                tag_q[i]  <= tag_d[i];
                line_q[i] <= line_d[i];
            end
        end
    end

    // R9: a discard leaves no line valid on the following cycle
    p_clear_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (valid_q == '0) && (dirty_q == '0));

endmodule

// File: rtl/nfc_ctrl.sv
module nfc_ctrl
    import nfc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int LINES      = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_cd,
    input  logic                        cfg_nw,
    input  logic                        cmd_inv,
    input  logic                        cmd_wbinv,
    output logic                        busy,
    output logic                        done,
    input  logic                        cpu_req_valid,
    output logic                        cpu_req_ready,
    input  logic                        cpu_req_we,
    input  logic [ADDR_W-1:0]           cpu_req_addr,
    input  logic [DATA_W-1:0]           cpu_req_wdata,
    input  logic [DATA_W/8-1:0]         cpu_req_be,
    output logic                        cpu_rsp_valid,
    output logic [DATA_W-1:0]           cpu_rsp_rdata,
    output logic                        mem_req_valid,
    input  logic                        mem_req_ready,
    output logic                        mem_req_we,
    output logic [ADDR_W-1:0]           mem_req_addr,
    output logic [LINE_BYTES*8-1:0]     mem_req_wdata,
    output logic [LINE_BYTES-1:0]       mem_req_be,
    input  logic                        mem_rsp_valid,
    input  logic [LINE_BYTES*8-1:0]     mem_rsp_rdata,
    output logic [$clog2(LINES)-1:0]    st_rd_idx,
    input  logic                        st_rd_valid,
    input  logic                        st_rd_dirty,
    input  logic [ADDR_W-$clog2(LINE_BYTES)-$clog2(LINES)-1:0] st_rd_tag,
    input  logic [LINE_BYTES*8-1:0]     st_rd_line,
    output logic                        st_wr_en,
    output logic [$clog2(LINES)-1:0]    st_wr_idx,
    output logic                        st_wr_valid,
    output logic                        st_wr_dirty,
    output logic [ADDR_W-$clog2(LINE_BYTES)-$clog2(LINES)-1:0] st_wr_tag,
    output logic [LINE_BYTES*8-1:0]     st_wr_line,
    output logic                        st_clr_all
);
    localparam int WORD_BYTES = DATA_W / 8;
    localparam int WORDS      = LINE_BYTES / WORD_BYTES;
    localparam int LINE_W     = LINE_BYTES * 8;
    localparam int OFS_W      = $clog2(LINE_BYTES);
    localparam int IDX_W      = $clog2(LINES);
    localparam int TAG_W      = ADDR_W - OFS_W - IDX_W;
    localparam int BOFS_W     = $clog2(WORD_BYTES);
    localparam int WSEL_W     = $clog2(WORDS);

    typedef struct packed {
        nfc_state_e          st;
        logic                we;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
        logic [WORD_BYTES-1:0] be;
        logic                alloc;
        logic [IDX_W-1:0]    scan;
        logic                rsp_valid;
        logic [DATA_W-1:0]   rdata;
        logic                done;
        logic                inv_pend;
        logic                wbinv_pend;
    } ctrl_t;

    ctrl_t d, q;

    logic [TAG_W-1:0]  r_tag;
    logic [IDX_W-1:0]  r_idx;
    logic [WSEL_W-1:0] r_wsel;
    logic              hit;

    assign r_tag  = q.addr[ADDR_W-1 -: TAG_W];
    assign r_idx  = q.addr[OFS_W +: IDX_W];
    assign r_wsel = q.addr[BOFS_W +: WSEL_W];
    assign hit    = st_rd_valid && (st_rd_tag == r_tag);

    function automatic logic [LINE_W-1:0] merge_word(
        input logic [LINE_W-1:0]     ln,
        input logic [WSEL_W-1:0]     ws,
        input logic [DATA_W-1:0]     wd,
        input logic [WORD_BYTES-1:0] be
    );
        logic [LINE_W-1:0] r;
        r = ln;
        for (int b = 0; b < WORD_BYTES; b++) begin
            if (be[b]) r[int'(ws)*DATA_W + b*8 +: 8] = wd[b*8 +: 8];
        end
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] pick_word(
        input logic [LINE_W-1:0] ln,
        input logic [WSEL_W-1:0] ws
    );
        return ln[int'(ws)*DATA_W +: DATA_W];
    endfunction

    assign busy          = (q.st == S_INV) || (q.st == S_WB_SCAN) || (q.st == S_WB_WR);
    assign done          = q.done;
    assign cpu_req_ready = (q.st == S_IDLE) && !q.inv_pend && !q.wbinv_pend;
    assign cpu_rsp_valid = q.rsp_valid;
    assign cpu_rsp_rdata = q.rdata;
    assign st_rd_idx     = busy ? q.scan : r_idx;

    always_comb begin
        d            = q;
        d.rsp_valid  = 1'b0;
        d.done       = 1'b0;

        st_wr_en     = 1'b0;
        st_wr_idx    = r_idx;
        st_wr_valid  = 1'b1;
        st_wr_dirty  = 1'b0;
        st_wr_tag    = r_tag;
        st_wr_line   = st_rd_line;
        st_clr_all   = 1'b0;

        mem_req_valid = 1'b0;
        mem_req_we    = 1'b0;
        mem_req_addr  = {r_tag, r_idx, {OFS_W{1'b0}}};
        mem_req_wdata = st_rd_line;
        mem_req_be    = '1;

        unique case (q.st)
            S_IDLE: begin
                if (q.inv_pend) begin
                    d.inv_pend = 1'b0;
                    d.st       = S_INV;
                end else if (q.wbinv_pend) begin
                    d.wbinv_pend = 1'b0;
                    d.scan       = '0;
                    d.st         = S_WB_SCAN;
                end else if (cpu_req_valid) begin
                    d.we    = cpu_req_we;
                    d.addr  = cpu_req_addr;
                    d.wdata = cpu_req_wdata;
                    d.be    = cpu_req_be;
                    d.st    = S_LOOK;
                end
            end
            S_LOOK: begin
                if (hit) begin
                    if (!q.we) begin
                        d.rsp_valid = 1'b1;
                        d.rdata     = pick_word(st_rd_line, r_wsel);
                        d.st        = S_IDLE;
                    end else begin
                        st_wr_en    = 1'b1;
                        st_wr_line  = merge_word(st_rd_line, r_wsel, q.wdata, q.be);
                        // absorbed writes are marked clean so they never leave
                        st_wr_dirty = cfg_nw ? 1'b0 : (cfg_cd ? st_rd_dirty : 1'b1);
                        if (cfg_cd && !cfg_nw) begin
                            d.st = S_WR_MEM;
                        end else begin
                            d.rsp_valid = 1'b1;
                            d.st        = S_IDLE;
                        end
                    end
                end else if (cfg_cd) begin
                    d.alloc = 1'b0;
                    d.st    = q.we ? S_WR_MEM : S_RD_REQ;
                end else begin
                    d.alloc = 1'b1;
                    d.st    = (st_rd_valid && st_rd_dirty) ? S_EVICT : S_RD_REQ;
                end
            end
            S_EVICT: begin
                mem_req_valid = 1'b1;
                mem_req_we    = 1'b1;
                mem_req_addr  = {st_rd_tag, r_idx, {OFS_W{1'b0}}};
                if (mem_req_ready) d.st = S_RD_REQ;
            end
            S_RD_REQ: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) d.st = S_RD_WAIT;
            end
            S_RD_WAIT: begin
                if (mem_rsp_valid) begin
                    d.rsp_valid = 1'b1;
                    d.rdata     = pick_word(mem_rsp_rdata, r_wsel);
                    d.st        = S_IDLE;
                    if (q.alloc) begin
                        st_wr_en    = 1'b1;
                        st_wr_line  = q.we ? merge_word(mem_rsp_rdata, r_wsel, q.wdata, q.be)
                                           : mem_rsp_rdata;
                        st_wr_dirty = q.we && !cfg_nw;
                    end
                end
            end
            S_WR_MEM: begin
                mem_req_valid = 1'b1;
                mem_req_we    = 1'b1;
                mem_req_wdata = {WORDS{q.wdata}};
                mem_req_be    = {{(LINE_BYTES-WORD_BYTES){1'b0}}, q.be} << (int'(r_wsel) * WORD_BYTES);
                if (mem_req_ready) begin
                    d.rsp_valid = 1'b1;
                    d.st        = S_IDLE;
                end
            end
            S_INV: begin
                st_clr_all = 1'b1;
                d.done     = 1'b1;
                d.st       = S_IDLE;
            end
            S_WB_SCAN, S_WB_WR: begin
                if (q.st == S_WB_SCAN && st_rd_valid && st_rd_dirty) begin
                    d.st = S_WB_WR;
                end else begin
                    if (q.st == S_WB_WR) begin
                        mem_req_valid = 1'b1;
                        mem_req_we    = 1'b1;
                        mem_req_addr  = {st_rd_tag, q.scan, {OFS_W{1'b0}}};
                    end
                    if (q.st == S_WB_SCAN || mem_req_ready) begin
                        st_wr_en    = 1'b1;
                        st_wr_idx   = q.scan;
                        st_wr_valid = 1'b0;
                        st_wr_dirty = 1'b0;
                        st_wr_tag   = st_rd_tag;
                        if (q.scan == IDX_W'(LINES-1)) begin
                            d.done = 1'b1;
                            d.st   = S_IDLE;
                        end else begin
                            d.scan = q.scan + 1'b1;
                            d.st   = S_WB_SCAN;
                        end
                    end
                end
            end
            default: d.st = S_IDLE;
        endcase

        if (cmd_inv)   d.inv_pend   = 1'b1;
        if (cmd_wbinv) d.wbinv_pend = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    // R11: the CPU port is closed while a command runs
    p_busy_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !cpu_req_ready);
    // R11: completion pulse lasts one cycle and follows a busy cycle
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_after_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && $past(busy));
    // R12: line-aligned requests, held until accepted
    p_align_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[OFS_W-1:0] == '0));
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we));
    // R9: discarding produces no memory traffic
    p_inv_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_clr_all |-> !mem_req_valid);
    // R2: responses are single pulses
    p_rsp_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rsp_valid |=> !cpu_rsp_valid);

endmodule

// File: rtl/nfc_cache.sv
module nfc_cache #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int LINES      = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_cd,
    input  logic                    cfg_nw,
    input  logic                    cmd_inv,
    input  logic                    cmd_wbinv,
    output logic                    busy,
    output logic                    done,
    input  logic                    cpu_req_valid,
    output logic                    cpu_req_ready,
    input  logic                    cpu_req_we,
    input  logic [ADDR_W-1:0]       cpu_req_addr,
    input  logic [DATA_W-1:0]       cpu_req_wdata,
    input  logic [DATA_W/8-1:0]     cpu_req_be,
    output logic                    cpu_rsp_valid,
    output logic [DATA_W-1:0]       cpu_rsp_rdata,
    output logic                    mem_req_valid,
    input  logic                    mem_req_ready,
    output logic                    mem_req_we,
    output logic [ADDR_W-1:0]       mem_req_addr,
    output logic [LINE_BYTES*8-1:0] mem_req_wdata,
    output logic [LINE_BYTES-1:0]   mem_req_be,
    input  logic                    mem_rsp_valid,
    input  logic [LINE_BYTES*8-1:0] mem_rsp_rdata
);
    localparam int LINE_W = LINE_BYTES * 8;
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = ADDR_W - $clog2(LINE_BYTES) - IDX_W;

    logic [IDX_W-1:0]  rd_idx, wr_idx;
    logic              rd_valid, rd_dirty, wr_en, wr_valid, wr_dirty, clr_all;
    logic [TAG_W-1:0]  rd_tag, wr_tag;
    logic [LINE_W-1:0] rd_line, wr_line;

    nfc_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_BYTES(LINE_BYTES), .LINES(LINES)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_cd(cfg_cd), .cfg_nw(cfg_nw),
        .cmd_inv(cmd_inv), .cmd_wbinv(cmd_wbinv), .busy(busy), .done(done),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_req_we(cpu_req_we), .cpu_req_addr(cpu_req_addr),
        .cpu_req_wdata(cpu_req_wdata), .cpu_req_be(cpu_req_be),
        .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_req_be(mem_req_be),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
        .st_rd_idx(rd_idx), .st_rd_valid(rd_valid), .st_rd_dirty(rd_dirty),
        .st_rd_tag(rd_tag), .st_rd_line(rd_line),
        .st_wr_en(wr_en), .st_wr_idx(wr_idx), .st_wr_valid(wr_valid),
        .st_wr_dirty(wr_dirty), .st_wr_tag(wr_tag), .st_wr_line(wr_line),
        .st_clr_all(clr_all)
    );

    nfc_store #(
        .LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_dirty(rd_dirty),
        .rd_tag(rd_tag), .rd_line(rd_line),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_dirty(wr_dirty),
        .wr_tag(wr_tag), .wr_line(wr_line), .clr_all(clr_all)
    );

endmodule

// File: tb/sim_nfc_cache.sv
module sim_nfc_cache;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_cd = 1'b0, cfg_nw = 1'b0, cmd_inv = 1'b0, cmd_wbinv = 1'b0;
    logic         busy, done;
    logic         cpu_req_valid = 1'b0, cpu_req_ready, cpu_req_we = 1'b0;
    logic [31:0]  cpu_req_addr = '0, cpu_req_wdata = '0;
    logic [3:0]   cpu_req_be = '0;
    logic         cpu_rsp_valid;
    logic [31:0]  cpu_rsp_rdata;
    logic         mem_req_valid, mem_req_we;
    logic         mem_req_ready = 1'b1;
    logic [31:0]  mem_req_addr;
    logic [127:0] mem_req_wdata;
    logic [15:0]  mem_req_be;
    logic         mem_rsp_valid = 1'b0;
    logic [127:0] mem_rsp_rdata = '0;

    int errors = 0, checks = 0;
    int rd_cnt = 0, wr_cnt = 0, misalign = 0;
    logic [127:0] mem [256];

    always #2 clk = ~clk;

    nfc_cache u0 (.*);

    // memory model: accepts every request, read data one cycle later
    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (mem_req_valid && mem_req_ready) begin
            if (mem_req_addr[3:0] != 4'h0) misalign <= misalign + 1;
            if (mem_req_we) begin
                wr_cnt <= wr_cnt + 1;
                for (int b = 0; b < 16; b++)
                    if (mem_req_be[b]) mem[mem_req_addr[11:4]][b*8 +: 8] <= mem_req_wdata[b*8 +: 8];
            end else begin
                rd_cnt        <= rd_cnt + 1;
                mem_rsp_valid <= 1'b1;
                mem_rsp_rdata <= mem[mem_req_addr[11:4]];
            end
        end
    end

    function automatic logic [31:0] iv(input logic [31:0] a);
        return 32'h5A00_0000 | (a & 32'h0000_0FFC);
    endfunction

    function automatic logic [31:0] mw(input logic [31:0] a);
        return mem[a[11:4]][a[3:2]*32 +: 32];
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic cpu(input logic we, input logic [31:0] a, input logic [31:0] wd,
                       input logic [3:0] be, output logic [31:0] rd);
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_we = we; cpu_req_addr = a;
        cpu_req_wdata = wd; cpu_req_be = be;
        while (!cpu_req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        cpu_req_valid = 1'b0;
        while (!cpu_rsp_valid) @(negedge clk);
        rd = cpu_rsp_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [31:0] a, input logic [31:0] exp,
                          input int drd, input int dwr);
        int r0, w0;
        logic [31:0] v;
        r0 = rd_cnt; w0 = wr_cnt;
        cpu(1'b0, a, '0, '0, v);
        @(negedge clk);
        check(req, "read data", v, exp);
        check(req, "memory reads", 32'(rd_cnt - r0), 32'(drd));
        check(req, "memory writes", 32'(wr_cnt - w0), 32'(dwr));
    endtask

    task automatic wr_chk(input string req, input logic [31:0] a, input logic [31:0] wd,
                          input logic [3:0] be, input int drd, input int dwr);
        int r0, w0;
        logic [31:0] v;
        r0 = rd_cnt; w0 = wr_cnt;
        cpu(1'b1, a, wd, be, v);
        @(negedge clk);
        check(req, "memory reads", 32'(rd_cnt - r0), 32'(drd));
        check(req, "memory writes", 32'(wr_cnt - w0), 32'(dwr));
    endtask

    // pulse a command, watch busy/ready/done, return number of memory writes
    task automatic command(input logic inv, output int nwr);
        int w0, seen_busy, stall_bad, n;
        w0 = wr_cnt; seen_busy = 0; stall_bad = 0; n = 0;
        @(negedge clk);
        cmd_inv = inv; cmd_wbinv = !inv;
        @(negedge clk);
        cmd_inv = 1'b0; cmd_wbinv = 1'b0;
        while (!done && n < 200) begin
            if (busy) seen_busy++;
            if (busy && cpu_req_ready) stall_bad++;
            @(negedge clk);
            n++;
        end
        check("R11", "done seen", 32'(done), 32'd1);
        check("R11", "busy cleared at done", 32'(busy), 32'd0);
        check("R11", "busy observed", 32'(seen_busy > 0), 32'd1);
        check("R11", "ready low while busy", 32'(stall_bad), 32'd0);
        @(negedge clk);
        check("R11", "done one cycle", 32'(done), 32'd0);
        nwr = wr_cnt - w0;
    endtask

    task automatic t_reset();
        check("R1", "busy after reset", 32'(busy), 32'd0);
        check("R1", "done after reset", 32'(done), 32'd0);
        check("R1", "ready after reset", 32'(cpu_req_ready), 32'd1);
        check("R1", "rsp after reset", 32'(cpu_rsp_valid), 32'd0);
    endtask

    task automatic t_normal();
        rd_chk("R2", 32'h100, iv(32'h100), 1, 0);
        rd_chk("R2", 32'h104, iv(32'h104), 0, 0);
        wr_chk("R3", 32'h104, 32'h1122_3344, 4'hF, 0, 0);
        rd_chk("R3", 32'h104, 32'h1122_3344, 0, 0);
        check("R3", "memory untouched before evict", mw(32'h104), iv(32'h104));
        rd_chk("R3", 32'h904, iv(32'h904), 1, 1);
        check("R3", "victim written back", mw(32'h104), 32'h1122_3344);
        wr_chk("R4", 32'h218, 32'hAABB_CCDD, 4'h3, 1, 0);
        rd_chk("R4", 32'h218, 32'h5A00_CCDD, 0, 0);
    endtask

    task automatic t_nofill();
        cfg_cd = 1'b1;
        rd_chk("R5", 32'h218, 32'h5A00_CCDD, 0, 0);
        rd_chk("R6", 32'h320, iv(32'h320), 1, 0);
        rd_chk("R6", 32'h320, iv(32'h320), 1, 0);
        wr_chk("R6", 32'h334, 32'h9988_7766, 4'hC, 0, 1);
        check("R6", "bypass write bytes", mw(32'h334), 32'h9988_0334);
        check("R6", "neighbour word intact", mw(32'h330), iv(32'h330));
        rd_chk("R6", 32'h334, 32'h9988_0334, 1, 0);
        wr_chk("R7", 32'h21C, 32'h0F0F_0F0F, 4'hF, 0, 1);
        check("R7", "write-through data", mw(32'h21C), 32'h0F0F_0F0F);
        rd_chk("R7", 32'h21C, 32'h0F0F_0F0F, 0, 0);
    endtask

    task automatic t_scratch();
        cfg_nw = 1'b1;
        wr_chk("R8", 32'h214, 32'hDEAD_BEEF, 4'hF, 0, 0);
        rd_chk("R8", 32'h214, 32'hDEAD_BEEF, 0, 0);
        cfg_cd = 1'b0; cfg_nw = 1'b0;
        rd_chk("R8", 32'hA10, iv(32'hA10), 1, 0);
        check("R8", "scratch word not written out", mw(32'h214), iv(32'h214));
        check("R8", "merged bytes dropped", mw(32'h218), iv(32'h218));
        rd_chk("R8", 32'h214, iv(32'h214), 1, 0);
    endtask

    task automatic t_inv();
        int n;
        wr_chk("R9", 32'h400, 32'h1234_5678, 4'hF, 1, 0);
        command(1'b1, n);
        check("R9", "no writes on discard", 32'(n), 32'd0);
        rd_chk("R9", 32'h400, iv(32'h400), 1, 0);
    endtask

    task automatic t_wbinv();
        int n;
        wr_chk("R10", 32'h500, 32'hAAAA_5555, 4'hF, 1, 0);
        wr_chk("R10", 32'h610, 32'h5555_AAAA, 4'hF, 1, 0);
        command(1'b0, n);
        check("R10", "writes on flush", 32'(n), 32'd2);
        check("R10", "flushed word A", mw(32'h500), 32'hAAAA_5555);
        check("R10", "flushed word B", mw(32'h610), 32'h5555_AAAA);
        rd_chk("R10", 32'h500, 32'hAAAA_5555, 1, 0);
    endtask

    task automatic run_all();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_normal();
        t_nofill();
        t_scratch();
        t_inv();
        t_wbinv();
        check("R12", "misaligned requests", 32'(misalign), 32'd0);
    endtask

    initial begin
        for (int l = 0; l < 256; l++)
            for (int w = 0; w < 4; w++)
                mem[l][w*32 +: 32] = iv(32'((l << 4) | (w << 2)));
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule